// File: doc/BRIEF.md
# Prescaled Capture Timer

A 16-bit up-counter that software can only read, never write. A selectable tick source drives it through a prescaler of 1, 2, 4 or 8. The source is a divided copy of the system clock, rising edges on an external clock pin, or nothing. Four capture channels sit beside the counter. Each one copies the live count into its own 16-bit register when its input pin shows a chosen edge, and it raises a request flag when it does.

The counter returns to zero on system reset. It also returns to zero on a rising edge of an external clear pin, but only when that pin is enabled. While the idle input is high, the counter and the prescaler are held at zero. The prescaler throws away any partial count whenever its division code or its source changes. A wrap of the low byte and a wrap of the full word each set their own flag, and the two flags feed one shared request line, each through its own enable.

Software reads every register one byte at a time through a plain select and data port. The data comes straight from the live registers, with no shadow copy. All flags stay set until software clears them with a one-cycle pulse. Every external pin passes through a two-stage synchronizer before its edges are detected.

Top module: `cap_timer16`

## Requirements
- R1: With `src_sel`=1 and `div_sel`=0, the counter advances by one every OSC_DIV clock cycles. It holds its value in any cycle with no prescaler output.
- R2: `div_sel` codes 0, 1, 2, 3 make the counter advance once per 1, 2, 4, 8 source ticks.
- R3: With `src_sel`=2, each synchronized rising edge of `ext_clk_pin` is one source tick. With `src_sel`=0 or 3 there are no ticks and the counter stands still.
- R4: The prescaler count is cleared in any cycle where `src_sel` or `div_sel` differs from its value in the previous cycle, and in any cycle where the counter is cleared.
- R5: A synchronized rising edge of `rt_pin` clears the counter when `rt_en`=1. When `rt_en`=0 it has no effect on the count.
- R6: While `idle`=1, the counter and the prescaler are held at zero, and the counter stays at zero in the cycle after.
- R7: Channel i uses `edge_cfg[2i]` to arm its rising edge and `edge_cfg[2i+1]` to arm its falling edge. On an armed synchronized edge, capture register i loads the count held in that cycle, and `cap_flag[i]` sets.
- R8: A channel whose two configuration bits are 00 never captures and never sets its flag.
- R9: `ovf_flags[0]` sets when the count steps from xxFF to xx00. `ovf_flags[1]` sets when it steps from FFFF to 0000. `ovf_irq` = (`ovf_flags[0]` & `ovf_lo_en`) | (`ovf_flags[1]` & `ovf_full_en`).
- R10: A flag falls only in the cycle after a clear pulse on its bit (`cap_flag_clr`, `ovf_flag_clr`). A set event in the same cycle wins over the clear.
- R11: `rd_data` shows a byte of a live register with no latching. `rd_sel`=0 gives the counter's low byte and 1 its high byte. `rd_sel`=2+2i gives the low byte of capture i and 3+2i its high byte. Any other value reads 0. All registers read 0 after reset.
- R12: A pin level that is sampled at clock edge n acts at edge n+2. A capture flag therefore shows at the third falling clock edge after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (oscillator rate) |
| rst_n | input | 1 | Asynchronous active-low system reset |
| src_sel | input | 2 | Tick source: 0 none, 1 divided clock, 2 external pin, 3 none |
| div_sel | input | 2 | Prescaler code: divide by 2^code |
| ext_clk_pin | input | 1 | External tick pin, rising edges counted |
| rt_pin | input | 1 | External counter-clear pin |
| rt_en | input | 1 | Enables clearing by `rt_pin` |
| idle | input | 1 | Holds counter and prescaler at zero |
| cap_pin | input | N_CAP | Capture input pins |
| edge_cfg | input | 2*N_CAP | Per-channel edge arming, {fall, rise} pairs |
| ovf_lo_en | input | 1 | Lets the low-byte wrap flag drive `ovf_irq` |
| ovf_full_en | input | 1 | Lets the full-wrap flag drive `ovf_irq` |
| rd_sel | input | RD_W | Byte select for reads |
| rd_data | output | 8 | Selected register byte |
| cap_flag | output | N_CAP | Capture request flags |
| cap_flag_clr | input | N_CAP | Clear pulses for capture flags |
| ovf_flags | output | 2 | {full wrap, low-byte wrap} flags |
| ovf_flag_clr | input | 2 | Clear pulses for the wrap flags |
| ovf_irq | output | 1 | Shared wrap request |

## Verification
The bench changes the division code and the source while ticks are arriving. If a design let the prescaler carry a stale partial count across a change, the counter would step early. The bench runs the counter all the way through its 16-bit wrap with only the full-wrap enable set. A design that confused the byte wrap with the word wrap would raise the shared request about 130,000 cycles too soon. It arms channels for rise only, fall only, both edges and neither. It pulses clear inputs while captures are arriving, and it counts edges to check the exact synchronizer latency. A missing or extra synchronizer stage would shift every capture value and flag by one cycle. The bench also pulses the clear pin with its enable off, and a design that ignored the enable would drop the count to zero.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_OSC    = 2'd1,
    SRC_PIN    = 2'd2,
    SRC_NONE_B = 2'd3
  } tick_src_e;

  // Last prescaler state before it emits an advance: 2^code - 1.
  function automatic logic [2:0] psc_last(input logic [1:0] div_code);
    logic [2:0] v;
    v = 3'd0;
    for (int k = 0; k < 3; k++) begin
      if (k < int'(div_code)) v[k] = 1'b1;
    end
    return v;
  endfunction

  function automatic logic rise_of(input logic now, input logic prev);
    return now & ~prev;
  endfunction

  function automatic logic fall_of(input logic now, input logic prev);
    return ~now & prev;
  endfunction

  // Channel fires when an armed edge is seen; cfg = {fall_arm, rise_arm}.
  function automatic logic edge_hit(input logic [1:0] cfg, input logic now, input logic prev);
    return (cfg[0] & rise_of(now, prev)) | (cfg[1] & fall_of(now, prev));
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_raw,
  output logic [W-1:0] sync_now,
  output logic [W-1:0] sync_prev
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q    <= '0;
      sync_now  <= '0;
      sync_prev <= '0;
    end else begin
      meta_q    <= pin_raw;
      sync_now  <= meta_q;
      sync_prev <= sync_now;
    end
  end
endmodule

// File: rtl/osc_divider.sv
module osc_divider #(
  parameter int OSC_DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic osc_tick
);
  localparam int CW = (OSC_DIV > 1) ? $clog2(OSC_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(OSC_DIV - 1);

  logic [CW-1:0] phase_q;

  assign osc_tick = (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (osc_tick) phase_q <= '0;
    else               phase_q <= phase_q + CW'(1);
  end
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler
  import cap_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src_sel,
  input  logic [1:0] div_sel,
  input  logic       osc_tick,
  input  logic       pin_rise,
  input  logic       hold_clr,
  output logic       adv,
  output logic       psc_clr,
  output logic [2:0] psc_cnt
);
  tick_src_e  src;
  logic [1:0] src_q, div_q;
  logic       tick, changed;
  logic [2:0] last;

  assign src = tick_src_e'(src_sel);

  always_comb begin
    case (src)
      SRC_OSC: tick = osc_tick;
      SRC_PIN: tick = pin_rise;
      default: tick = 1'b0;
    endcase
  end

  assign changed = (src_sel != src_q) || (div_sel != div_q);
  assign psc_clr = changed | hold_clr;
  assign last    = psc_last(div_sel);
  assign adv     = !psc_clr && tick && (psc_cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= 2'd0;
      div_q   <= 2'd0;
      psc_cnt <= 3'd0;
    end else begin
      src_q <= src_sel;
      div_q <= div_sel;
      if (psc_clr)   psc_cnt <= 3'd0;
      else if (tick) psc_cnt <= (psc_cnt == last) ? 3'd0 : psc_cnt + 3'd1;
    end
  end
endmodule

// File: rtl/capture_bank.sv
module capture_bank
  import cap_timer_pkg::*;
#(
  parameter int N_CAP = 4,
  parameter int TMR_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [TMR_W-1:0]            tmr_val,
  input  logic [2*N_CAP-1:0]          edge_cfg,
  input  logic [N_CAP-1:0]            pin_now,
  input  logic [N_CAP-1:0]            pin_prev,
  input  logic [N_CAP-1:0]            flag_clr,
  output logic [N_CAP-1:0][TMR_W-1:0] cap_val,
  output logic [N_CAP-1:0]            cap_flag,
  output logic [N_CAP-1:0]            cap_evt
);
  for (genvar i = 0; i < N_CAP; i++) begin : g_ch
    assign cap_evt[i] = edge_hit(edge_cfg[2*i +: 2], pin_now[i], pin_prev[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cap_val[i]  <= '0;
        cap_flag[i] <= 1'b0;
      end else begin
        if (cap_evt[i]) cap_val[i] <= tmr_val;
        cap_flag[i] <= cap_evt[i] | (cap_flag[i] & ~flag_clr[i]);
      end
    end
  end
endmodule

// File: rtl/cap_timer16.sv
module cap_timer16 #(
  parameter int TMR_W   = 16,
  parameter int N_CAP   = 4,
  parameter int OSC_DIV = 12,
  localparam int BYTES  = TMR_W / 8,
  localparam int N_REGS = N_CAP + 1,
  localparam int RD_W   = $clog2(N_REGS * BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           src_sel,
  input  logic [1:0]           div_sel,
  input  logic                 ext_clk_pin,
  input  logic                 rt_pin,
  input  logic                 rt_en,
  input  logic                 idle,
  input  logic [N_CAP-1:0]     cap_pin,
  input  logic [2*N_CAP-1:0]   edge_cfg,
  input  logic                 ovf_lo_en,
  input  logic                 ovf_full_en,
  input  logic [RD_W-1:0]      rd_sel,
  output logic [7:0]           rd_data,
  output logic [N_CAP-1:0]     cap_flag,
  input  logic [N_CAP-1:0]     cap_flag_clr,
  output logic [1:0]           ovf_flags,
  input  logic [1:0]           ovf_flag_clr,
  output logic                 ovf_irq
);
  import cap_timer_pkg::*;

  localparam int NP = N_CAP + 2;
  localparam int RT_IDX  = N_CAP;
  localparam int EXT_IDX = N_CAP + 1;

  logic [NP-1:0] raw_pins, s_now, s_prev;
  logic          osc_tick, rt_evt, tmr_clr, tmr_adv, psc_clr;
  logic [2:0]    psc_cnt;
  logic [TMR_W-1:0] tmr_q;
  logic          lo_wrap, full_wrap;
  logic [N_CAP-1:0][TMR_W-1:0] cap_val;
  logic [N_CAP-1:0] cap_evt;
  logic [N_REGS-1:0][TMR_W-1:0] regs_all;

  assign raw_pins = {ext_clk_pin, rt_pin, cap_pin};

  pin_sync #(.W(NP)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_raw(raw_pins),
    .sync_now(s_now), .sync_prev(s_prev)
  );

  osc_divider #(.OSC_DIV(OSC_DIV)) u_osc (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick)
  );

  assign rt_evt  = rt_en & rise_of(s_now[RT_IDX], s_prev[RT_IDX]);
  assign tmr_clr = idle | rt_evt;

  tick_prescaler u_psc (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .div_sel(div_sel),
    .osc_tick(osc_tick),
    .pin_rise(rise_of(s_now[EXT_IDX], s_prev[EXT_IDX])),
    .hold_clr(tmr_clr), .adv(tmr_adv), .psc_clr(psc_clr), .psc_cnt(psc_cnt)
  );

  assign lo_wrap   = tmr_adv & (&tmr_q[7:0]);
  assign full_wrap = tmr_adv & (&tmr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q     <= '0;
      ovf_flags <= 2'b00;
    end else begin
      if (tmr_clr)      tmr_q <= '0;
      else if (tmr_adv) tmr_q <= tmr_q + TMR_W'(1);
      ovf_flags[0] <= lo_wrap   | (ovf_flags[0] & ~ovf_flag_clr[0]);
      ovf_flags[1] <= full_wrap | (ovf_flags[1] & ~ovf_flag_clr[1]);
    end
  end

  assign ovf_irq = (ovf_flags[0] & ovf_lo_en) | (ovf_flags[1] & ovf_full_en);

  capture_bank #(.N_CAP(N_CAP), .TMR_W(TMR_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .tmr_val(tmr_q), .edge_cfg(edge_cfg),
    .pin_now(s_now[N_CAP-1:0]), .pin_prev(s_prev[N_CAP-1:0]),
    .flag_clr(cap_flag_clr), .cap_val(cap_val), .cap_flag(cap_flag),
    .cap_evt(cap_evt)
  );

  assign regs_all = {cap_val, tmr_q};

  always_comb begin
    rd_data = 8'h00;
    for (int r = 0; r < N_REGS; r++) begin
      for (int b = 0; b < BYTES; b++) begin
        if (rd_sel == RD_W'(r * BYTES + b)) rd_data = regs_all[r][b*8 +: 8];
      end
    end
  end
endmodule

module cap_timer16_chk #(
  parameter int TMR_W = 16,
  parameter int N_CAP = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        idle,
  input logic [TMR_W-1:0]            tmr_q,
  input logic                        tmr_adv,
  input logic                        tmr_clr,
  input logic                        psc_clr,
  input logic [2:0]                  psc_cnt,
  input logic [N_CAP-1:0][TMR_W-1:0] cap_val,
  input logic [N_CAP-1:0]            cap_evt,
  input logic [N_CAP-1:0]            cap_flag,
  input logic [N_CAP-1:0]            cap_flag_clr,
  input logic [2*N_CAP-1:0]          edge_cfg,
  input logic [1:0]                  ovf_flags,
  input logic                        lo_wrap,
  input logic                        full_wrap
);
  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_clr && !tmr_adv) |=> $stable(tmr_q)); // R1
  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_adv && !tmr_clr) |=> (tmr_q == TMR_W'($past(tmr_q) + TMR_W'(1)))); // R1
  AST_PSC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    psc_clr |=> (psc_cnt == 3'd0)); // R4
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> (tmr_q == '0)); // R6
  AST_LO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wrap |=> ovf_flags[0]); // R9
  AST_FULL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    full_wrap |=> (ovf_flags[1] && tmr_q == '0)); // R9

  for (genvar i = 0; i < N_CAP; i++) begin : g_chk
    AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[i] |=> (cap_val[i] == $past(tmr_q) && cap_flag[i])); // R7
    AST_CAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_cfg[2*i +: 2] == 2'b00) |-> !cap_evt[i]); // R8
    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_flag[i] && !cap_flag_clr[i]) |=> cap_flag[i]); // R10
  end
endmodule

bind cap_timer16 cap_timer16_chk #(.TMR_W(TMR_W), .N_CAP(N_CAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .idle(idle), .tmr_q(tmr_q), .tmr_adv(tmr_adv),
  .tmr_clr(tmr_clr), .psc_clr(psc_clr), .psc_cnt(psc_cnt), .cap_val(cap_val),
  .cap_evt(cap_evt), .cap_flag(cap_flag), .cap_flag_clr(cap_flag_clr),
  .edge_cfg(edge_cfg), .ovf_flags(ovf_flags), .lo_wrap(lo_wrap),
  .full_wrap(full_wrap)
);

// File: tb/cap_timer16_test.sv
module cap_timer16_test;
  localparam int CLK_PERIOD = 10;
  localparam int OSCD = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] src_sel = 0, div_sel = 0;
  logic ext_clk_pin = 0, rt_pin = 0, rt_en = 0, idle = 0;
  logic [3:0] cap_pin = 0, cap_flag_clr = 0, cap_flag;
  logic [7:0] edge_cfg = 0, rd_data;
  logic ovf_lo_en = 0, ovf_full_en = 0, ovf_irq;
  logic [3:0] rd_sel = 0;
  logic [1:0] ovf_flags, ovf_flag_clr = 0;

  int total = 0, bad = 0;
  string phase_tag = "R1";
  bit done = 0;

  cap_timer16 #(.OSC_DIV(OSCD)) uut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .div_sel(div_sel),
    .ext_clk_pin(ext_clk_pin), .rt_pin(rt_pin), .rt_en(rt_en), .idle(idle),
    .cap_pin(cap_pin), .edge_cfg(edge_cfg), .ovf_lo_en(ovf_lo_en),
    .ovf_full_en(ovf_full_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .cap_flag(cap_flag), .cap_flag_clr(cap_flag_clr), .ovf_flags(ovf_flags),
    .ovf_flag_clr(ovf_flag_clr), .ovf_irq(ovf_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_tmr = 0, m_psc = 0, m_oph = 0, m_src_p = 0, m_div_p = 0;
  bit [5:0] h1 = 0, h2 = 0, h3 = 0;   // pin samples 1, 2, 3 edges back
  int m_cap[4] = '{0, 0, 0, 0};
  bit m_cf[4]  = '{0, 0, 0, 0};
  bit m_lo = 0, m_full = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tmr = 0; m_psc = 0; m_oph = 0; m_src_p = 0; m_div_p = 0;
      h1 = 0; h2 = 0; h3 = 0; m_lo = 0; m_full = 0;
      foreach (m_cap[k]) begin m_cap[k] = 0; m_cf[k] = 0; end
    end else begin
      bit [5:0] rise, fall;
      bit tick, adv, clr, chg, int_tick;
      int limit;
      rise = h2 & ~h3;
      fall = ~h2 & h3;
      int_tick = (m_oph == OSCD - 1);
      m_oph = (m_oph + 1) % OSCD;
      tick = (src_sel == 1) ? int_tick : (src_sel == 2) ? rise[5] : 1'b0;
      clr = idle || (rt_en && rise[4]);
      chg = (int'(src_sel) != m_src_p) || (int'(div_sel) != m_div_p);
      m_src_p = src_sel; m_div_p = div_sel;
      limit = (1 << div_sel) - 1;
      adv = 0;
      if (chg || clr) m_psc = 0;
      else if (tick) begin
        adv = (m_psc == limit);
        m_psc = adv ? 0 : m_psc + 1;
      end
      for (int k = 0; k < 4; k++) begin
        if ((edge_cfg[2*k] && rise[k]) || (edge_cfg[2*k+1] && fall[k])) begin
          m_cap[k] = m_tmr; m_cf[k] = 1;
        end else if (cap_flag_clr[k]) m_cf[k] = 0;
      end
      if (adv && (m_tmr % 256) == 255) m_lo = 1; else if (ovf_flag_clr[0]) m_lo = 0;
      if (adv && m_tmr == 65535) m_full = 1; else if (ovf_flag_clr[1]) m_full = 0;
      if (clr) m_tmr = 0; else if (adv) m_tmr = (m_tmr + 1) % 65536;
      h3 = h2; h2 = h1;
      h1 = {ext_clk_pin, rt_pin, cap_pin};
    end
  end

  // Per-cycle comparison, away from the active edge
  int sel_next = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int r, b, word, exp_b;
      bit [3:0] ef;
      rd_sel = 4'(sel_next);
      #1;
      r = sel_next / 2; b = sel_next % 2;
      word = (r == 0) ? m_tmr : m_cap[r-1];
      exp_b = (word >> (8*b)) & 255;
      if (r == 0) chk(rd_data == 8'(exp_b), {phase_tag, "/R11 timer byte"}, rd_data, exp_b);
      else        chk(rd_data == 8'(exp_b), "R7 capture byte", rd_data, exp_b);
      ef = {m_cf[3], m_cf[2], m_cf[1], m_cf[0]};
      chk(cap_flag == ef, "R10 capture flags", cap_flag, ef);
      chk(ovf_flags == {m_full, m_lo}, "R9 wrap flags", ovf_flags, {m_full, m_lo});
      chk(ovf_irq == ((m_lo && ovf_lo_en) || (m_full && ovf_full_en)), "R9 shared request",
          ovf_irq, (m_lo && ovf_lo_en) || (m_full && ovf_full_en));
      sel_next = (sel_next + 1) % 10;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    chk(cap_flag == 0, "R11 reset flags", cap_flag, 0);
    chk(ovf_flags == 0, "R11 reset wrap flags", ovf_flags, 0);
    chk(ovf_irq == 0, "R9 reset request", ovf_irq, 0);
    rst_n = 1;
    phase_tag = "R1";  src_sel = 1; div_sel = 0; cyc(40);
    phase_tag = "R2";  div_sel = 1; cyc(60); div_sel = 3; cyc(120); div_sel = 2; cyc(60);
    phase_tag = "R4";
    for (int i = 0; i < 8; i++) begin div_sel = 2'(i % 4); cyc(5); end
    src_sel = 2; cyc(3); src_sel = 1; cyc(10);
    phase_tag = "R3";  src_sel = 2; div_sel = 1;
    for (int i = 0; i < 60; i++) begin ext_clk_pin = ~ext_clk_pin; cyc(3); end
    src_sel = 0;
    for (int i = 0; i < 10; i++) begin ext_clk_pin = ~ext_clk_pin; cyc(3); end
    src_sel = 3;
    for (int i = 0; i < 10; i++) begin ext_clk_pin = ~ext_clk_pin; cyc(3); end
    phase_tag = "R5";  src_sel = 1; div_sel = 0; rt_en = 0; cyc(20);
    rt_pin = 1; cyc(4); rt_pin = 0; cyc(20);
    rt_en = 1; rt_pin = 1; cyc(4); rt_pin = 0; cyc(20); rt_en = 0;
    phase_tag = "R6";  idle = 1; cyc(20); idle = 0; cyc(30);
    phase_tag = "R7";  edge_cfg = 8'b11_00_10_01;
    for (int i = 0; i < 24; i++) begin
      cap_pin = 4'(i * 5 + 3);
      cyc(7);
      if (i % 3 == 2) begin cap_flag_clr = 4'hF; cyc(1); cap_flag_clr = 0; end
    end
    chk(cap_flag[2] == 0, "R8 unarmed channel flag", cap_flag[2], 0);
    phase_tag = "R12"; cap_pin = 0; cyc(6);
    cap_flag_clr = 4'hF; cyc(1); cap_flag_clr = 0;
    cap_pin[0] = 1;
    cyc(2); chk(cap_flag[0] == 0, "R12 flag before latency", cap_flag[0], 0);
    cyc(1); chk(cap_flag[0] == 1, "R12 flag after latency", cap_flag[0], 1);
    phase_tag = "R10"; cap_flag_clr = 4'h1; cyc(1); cap_flag_clr = 0; cyc(1);
    chk(cap_flag[0] == 0, "R10 flag cleared", cap_flag[0], 0);
    phase_tag = "R9";  rt_en = 1; rt_pin = 1; cyc(4); rt_pin = 0; cyc(2); rt_en = 0;
    ovf_lo_en = 1; cyc(600);
    chk(ovf_flags[0] == 1, "R9 low-byte wrap flag", ovf_flags[0], 1);
    chk(ovf_irq == 1, "R9 request from low byte", ovf_irq, 1);
    ovf_flag_clr = 2'b01; cyc(1); ovf_flag_clr = 0;
    ovf_lo_en = 0; ovf_full_en = 1; cyc(1);
    chk(ovf_irq == 0, "R9 request masked", ovf_irq, 0);
    cyc(130560);
    chk(ovf_flags[1] == 1, "R9 full wrap flag", ovf_flags[1], 1);
    chk(ovf_irq == 1, "R9 request from full wrap", ovf_irq, 1);
    cyc(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule